// File: doc/BRIEF.md
# Multiprocessor Level Interrupt Controller

This block gathers the interrupt lines of a small multiprocessor system (onboard devices, two sets of seven bus-level lines and four asynchronous error sources) and turns them into a 4-bit priority level for each of up to four processors. A single global mask register gates the device and error lines; a set bit blocks its source. Software never writes the mask directly. One address sets the bits written as one, and a second address clears them. The top mask bit gates every hardware source at once.

Device lines are steered to one processor chosen by a programmable target register. The error lines go to every processor at the top level. Each processor also owns a register of fifteen soft-interrupt bits and a mask bit for its own level-14 tick input. Both are changed through set and clear aliases. Any processor can write another processor's set alias to raise an inter-processor interrupt. Each processor receives the highest pending level, registered one clock after its inputs. A read-only pending word gives the raw state of all global lines.

Top module: `mp_level_intc`

## Requirements
- R1: After reset the global mask reads 0xFFFFFFFF, the target register reads 0, every per-processor register reads 0x00000080 (soft bits clear, tick masked) and every level output is 0.
- R2: A write to word address 2 sets the mask bits that are one in the data, and a write to word address 3 clears them. Zero data bits and writes to read-only addresses leave all state unchanged. The mask reads back at word address 1.
- R3: While mask bit 31 is set, no device, error or tick source raises any level, but soft interrupts still do.
- R4: Device bit to level mapping is as follows. Bits 0..6 and 7..13 both give levels 2,3,5,7,9,11,13 in ascending bit order. Bits 14 and 15 give level 12. Bit 16 gives 6, bit 17 gives 13, bit 18 gives 4, bit 19 gives 10, bit 20 gives 8, bit 21 gives 9 and bit 22 gives 11. Bits 23..26 and 31 carry no source.
- R5: An unmasked, asserted error line (bits 27..30) drives level 15 on every processor, whatever the target register holds.
- R6: Unmasked device sources reach only the processor whose index is in the target register. The target register is read and written at word address 4.
- R7: Processor c has a register read at word 16+4c, with a set alias at 17+4c and a clear alias at 18+4c. Bit 16+L holds the soft interrupt of level L (1..15). A set write to another processor's alias raises that processor's level.
- R8: Bit 7 of a processor's register masks its own tick input, which raises level 14 on that processor only.
- R9: Word address 0 reads the raw global input lines, unaffected by masks, with bits 23..26 and 31 forced to zero.
- R10: Each level output equals the highest pending unmasked level of that processor, or 0. It changes on the clock edge after the sources, masks or registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current word address |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dev_irq | input | 32 | Global device and error lines, active high |
| cpu_tick | input | NCPU | Per-processor level-14 tick lines |
| cpu_level | output | 4*NCPU | Level to processor c in bits 4c+3..4c |

## Verification
On every cycle the assertions check the following. Set and clear writes leave the written bits in the right state. The target only changes when written. An error line forces level 15 on every processor one edge later. An unmasked tick yields at least level 14. An empty candidate set yields level 0, and a non-empty one yields a non-zero level. The level mapping of each device bit, steering to the chosen target, the master bit sparing soft interrupts, and priority between simultaneous levels on each processor can only be shown by the bench's scenarios. There, a behavioural model predicts every processor's level each clock.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int WORD_W     = 32;
  localparam int MASTER_BIT = 31;
  localparam int ERR_LO     = 27;
  localparam int ERR_HI     = 30;
  localparam int DEV_TOP    = 22;
  localparam int SOFT_BASE  = 16;  // level L soft bit sits at SOFT_BASE+L
  localparam int TICK_MBIT  = 7;
  localparam int TICK_LVL   = 14;
  localparam int ERR_LVL    = 15;
  localparam logic [WORD_W-1:0] LINE_VALID = 32'h787F_FFFF;

  typedef logic [15:1] lvl_vec_t;

  // fixed device bit to processor level mapping
  function automatic logic [3:0] src_level(input int b);
    case (b)
      0, 7:   return 4'd2;
      1, 8:   return 4'd3;
      2, 9:   return 4'd5;
      3, 10:  return 4'd7;
      4, 11:  return 4'd9;
      5, 12:  return 4'd11;
      6, 13:  return 4'd13;
      14, 15: return 4'd12;
      16:     return 4'd6;
      17:     return 4'd13;
      18:     return 4'd4;
      19:     return 4'd10;
      20:     return 4'd8;
      21:     return 4'd9;
      22:     return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  function automatic lvl_vec_t dev_levels(input logic [WORD_W-1:0] act);
    logic [15:0] v;
    v = '0;
    for (int b = 0; b <= DEV_TOP; b++)
      if (act[b]) v[src_level(b)] = 1'b1;
    return v[15:1];
  endfunction

  function automatic logic [3:0] top_level(input lvl_vec_t v);
    logic [3:0] r;
    r = 4'd0;
    for (int l = 1; l <= 15; l++)
      if (v[l]) r = 4'(l);
    return r;
  endfunction
endpackage

// File: rtl/lic_glob_regs.sv
module lic_glob_regs
  import lic_pkg::*;
#(
  parameter int TGT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              tgt_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] mask_q,
  output logic [TGT_W-1:0]  tgt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      tgt_q  <= '0;
    end else begin
      if (set_we) mask_q <= mask_q | wdata;
      if (clr_we) mask_q <= mask_q & ~wdata;
      if (tgt_we) tgt_q  <= wdata[TGT_W-1:0];
    end
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(wdata)) == '0));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask_q));
  // R6
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_we |=> $stable(tgt_q));
endmodule

// File: rtl/lic_cpu_port.sv
module lic_cpu_port
  import lic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [15:1]       soft_d,
  input  logic              tick_d,
  input  lvl_vec_t          glob_lv,
  input  logic              err_in,
  input  logic              tick_in,
  input  logic              hard_blk,
  output logic [WORD_W-1:0] reg_rd,
  output logic [3:0]        level_q
);
  logic [15:1] soft_q;
  logic        tmask_q;
  logic        tick_live;
  lvl_vec_t    cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q  <= '0;
      tmask_q <= 1'b1;
    end else begin
      if (set_we) begin
        soft_q <= soft_q | soft_d;
        if (tick_d) tmask_q <= 1'b1;
      end
      if (clr_we) begin
        soft_q <= soft_q & ~soft_d;
        if (tick_d) tmask_q <= 1'b0;
      end
    end
  end

  assign tick_live = tick_in && !tmask_q && !hard_blk;

  always_comb begin
    cand = soft_q | glob_lv;
    if (err_in)    cand[ERR_LVL]  = 1'b1;
    if (tick_live) cand[TICK_LVL] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 4'd0;
    else        level_q <= top_level(cand);
  end

  always_comb begin
    reg_rd = '0;
    reg_rd[WORD_W-1:SOFT_BASE+1] = soft_q;
    reg_rd[TICK_MBIT] = tmask_q;
  end

  // R5
  err_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_in |=> (level_q == 4'd15));
  // R7
  soft_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && soft_d[15]) |=> ##1 (level_q == 4'd15));
  // R8
  tick_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_live |=> (level_q >= 4'd14));
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |=> (level_q == 4'd0));
  // R10
  busy_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |=> (level_q != 4'd0));
endmodule

// File: rtl/mp_level_intc.sv
module mp_level_intc
  import lic_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [WORD_W-1:0]   dev_irq,
  input  logic [NCPU-1:0]     cpu_tick,
  output logic [4*NCPU-1:0]   cpu_level
);
  localparam int TGT_W    = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int CPU_BASE = 16;
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TGT   = ADDR_W'(4);

  logic [WORD_W-1:0] mask_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [WORD_W-1:0] lines;
  logic [WORD_W-1:0] active;
  logic              master_on;
  logic              err_any;
  lvl_vec_t          dev_lv;
  logic [WORD_W-1:0] cpu_rd [NCPU];

  lic_glob_regs #(.TGT_W(TGT_W)) u_glob (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (bus_wr && bus_addr == A_MSET),
    .clr_we (bus_wr && bus_addr == A_MCLR),
    .tgt_we (bus_wr && bus_addr == A_TGT),
    .wdata  (bus_wdata),
    .mask_q (mask_q),
    .tgt_q  (tgt_q)
  );

  assign lines     = dev_irq & LINE_VALID;
  assign master_on = mask_q[MASTER_BIT];
  assign active    = master_on ? '0 : (lines & ~mask_q);
  assign err_any   = |active[ERR_HI:ERR_LO];
  assign dev_lv    = dev_levels(active);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CPU_BASE + 4 * c);
    lvl_vec_t steer_lv;
    assign steer_lv = (tgt_q == TGT_W'(c)) ? dev_lv : '0;

    lic_cpu_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (bus_wr && bus_addr == BASE + ADDR_W'(1)),
      .clr_we   (bus_wr && bus_addr == BASE + ADDR_W'(2)),
      .soft_d   (bus_wdata[WORD_W-1:SOFT_BASE+1]),
      .tick_d   (bus_wdata[TICK_MBIT]),
      .glob_lv  (steer_lv),
      .err_in   (err_any),
      .tick_in  (cpu_tick[c]),
      .hard_blk (master_on),
      .reg_rd   (cpu_rd[c]),
      .level_q  (cpu_level[4*c +: 4])
    );

    // R6
    steer_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q != TGT_W'(c)) |-> (steer_lv == '0));
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PEND:  bus_rdata = lines;
      A_MASK:  bus_rdata = mask_q;
      A_TGT:   bus_rdata = WORD_W'(tgt_q);
      default: bus_rdata = '0;
    endcase
    for (int c = 0; c < NCPU; c++)
      if (bus_addr == ADDR_W'(CPU_BASE + 4 * c)) bus_rdata = cpu_rd[c];
  end

  // R3
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_on |-> (active == '0));
endmodule

// File: tb/tb_mp_level_intc.sv
module tb_mp_level_intc;
  localparam int NCPU = 4;
  localparam int AW   = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [31:0]       dev = '0;
  logic [NCPU-1:0]   tick = '0;
  logic [4*NCPU-1:0] cpu_level;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [31:0] m_mask;
  int          m_tgt;
  logic [15:0] m_soft [NCPU];
  bit          m_tmask [NCPU];
  int          exp_lv [NCPU];

  mp_level_intc #(.NCPU(NCPU), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq(dev),
    .cpu_tick(tick), .cpu_level(cpu_level)
  );

  always #2 clk = ~clk;

  function automatic int bench_map(int b);
    int k;
    if (b <= 13) begin
      k = (b <= 6) ? b : b - 7;
      return (k == 0) ? 2 : 2 * k + 1;
    end
    if (b == 14 || b == 15) return 12;
    if (b == 16) return 6;
    if (b == 17) return 13;
    if (b == 18) return 4;
    if (b == 19) return 10;
    if (b == 20) return 8;
    if (b == 21) return 9;
    if (b == 22) return 11;
    return 0;
  endfunction

  function automatic int model_level(int c);
    bit hard_ok;
    hard_ok = !m_mask[31];
    for (int l = 15; l >= 1; l--) begin
      if (m_soft[c][l]) return l;
      if (hard_ok) begin
        if (l == 15)
          for (int b = 27; b <= 30; b++) if (dev[b] && !m_mask[b]) return l;
        if (l == 14 && tick[c] && !m_tmask[c]) return l;
        if (c == m_tgt)
          for (int b = 0; b <= 22; b++)
            if (dev[b] && !m_mask[b] && bench_map(b) == l) return l;
      end
    end
    return 0;
  endfunction

  function automatic logic [31:0] model_read(int a);
    logic [31:0] r;
    r = 0;
    if (a == 0) for (int b = 0; b < 32; b++) if ((b <= 22 || (b >= 27 && b <= 30)) && dev[b]) r[b] = 1'b1;
    if (a == 1) r = m_mask;
    if (a == 4) r = 32'(m_tgt);
    for (int c = 0; c < NCPU; c++)
      if (a == 16 + 4 * c) begin
        for (int l = 1; l <= 15; l++) r[16 + l] = m_soft[c][l];
        r[7] = m_tmask[c];
      end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 32'hFFFF_FFFF;
      m_tgt  = 0;
      for (int c = 0; c < NCPU; c++) begin
        m_soft[c] = 0; m_tmask[c] = 1; exp_lv[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCPU; c++) exp_lv[c] = model_level(c);
      if (bus_wr) begin
        int a;
        a = int'(bus_addr);
        if (a == 2) m_mask = m_mask | bus_wdata;
        if (a == 3) m_mask = m_mask & ~bus_wdata;
        if (a == 4) m_tgt = int'(bus_wdata[1:0]);
        for (int c = 0; c < NCPU; c++) begin
          for (int l = 1; l <= 15; l++) begin
            if (a == 17 + 4 * c && bus_wdata[16 + l]) m_soft[c][l] = 1'b1;
            if (a == 18 + 4 * c && bus_wdata[16 + l]) m_soft[c][l] = 1'b0;
          end
          if (a == 17 + 4 * c && bus_wdata[7]) m_tmask[c] = 1;
          if (a == 18 + 4 * c && bus_wdata[7]) m_tmask[c] = 0;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] expv, string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done)
      for (int c = 0; c < NCPU; c++)
        check(cur_req, 32'(cpu_level[4*c +: 4]), 32'(exp_lv[c]), $sformatf("model level cpu%0d", c));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(string req, int a, logic [31:0] expv);
    @(negedge clk);
    bus_addr = AW'(a);
    #1;
    check(req, bus_rdata, expv, $sformatf("read addr %0d", a));
    check(req, bus_rdata, model_read(a), $sformatf("model read addr %0d", a));
  endtask

  task automatic lv(string req, int c, int expv);
    @(negedge clk);
    check(req, 32'(cpu_level[4*c +: 4]), 32'(expv), $sformatf("level cpu%0d", c));
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    rd("R1", 1, 32'hFFFF_FFFF);
    rd("R1", 4, 0);
    for (int c = 0; c < NCPU; c++) rd("R1", 16 + 4 * c, 32'h0000_0080);
    lv("R1", 0, 0);

    // R9 raw lines visible while everything is masked
    cur_req = "R9";
    dev = 32'hFFFF_FFFF;
    wait_cyc(2);
    rd("R9", 0, 32'h787F_FFFF);
    lv("R9", 0, 0);
    dev = 0;

    // R2 set/clear aliases, zero bits keep state, read-only ignored
    cur_req = "R2";
    wr(3, 32'h8004_0000);
    rd("R2", 1, 32'h7FFB_FFFF);
    wr(2, 32'h0000_0000);
    wr(3, 32'h0000_0000);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h0000_0000);
    rd("R2", 1, 32'h7FFB_FFFF);

    // R4 SCSI line to target 0
    cur_req = "R4";
    dev = 32'h0004_0000;
    wait_cyc(2);
    lv("R4", 0, 4);
    lv("R4", 1, 0);
    wr(2, 32'h0004_0000);

    // R4 walk every device bit alone
    for (int b = 0; b <= 22; b++) begin
      dev = 32'(1) << b;
      wr(3, 32'(1) << b);
      wait_cyc(1);
      lv("R4", 0, bench_map(b));
      wr(2, 32'(1) << b);
    end

    // R10 priority among simultaneous device lines
    cur_req = "R10";
    dev = 32'h0014_0001;  // bits 0 (2), 18 (4), 20 (8)
    wr(3, 32'h0014_0001);
    wait_cyc(1);
    lv("R10", 0, 8);
    dev = 32'h0004_0001;
    wait_cyc(1);
    lv("R10", 0, 4);

    // R6 steering to processor 2
    cur_req = "R6";
    wr(4, 2);
    rd("R6", 4, 2);
    wait_cyc(1);
    lv("R6", 2, 4);
    lv("R6", 0, 0);

    // R5 error broadcast
    cur_req = "R5";
    dev = dev | 32'h1000_0000;
    wr(3, 32'h1000_0000);
    wait_cyc(1);
    for (int c = 0; c < NCPU; c++) lv("R5", c, 15);
    dev = 32'h0004_0001;

    // R8 tick: masked by default, then unmasked on processor 3 only
    cur_req = "R8";
    tick = 4'b1000;
    wait_cyc(2);
    lv("R8", 3, 0);
    wr(30, 32'h0000_0080);
    rd("R8", 28, 32'h0000_0000);
    wait_cyc(1);
    lv("R8", 3, 14);
    lv("R8", 1, 0);

    // R3 master bit blocks hard sources but not soft
    cur_req = "R3";
    dev = dev | 32'h1000_0000;
    wr(2, 32'h8000_0000);
    wait_cyc(1);
    lv("R3", 3, 0);
    lv("R3", 2, 0);
    wr(21, 32'h0020_0000);   // soft level 5 on processor 1
    wait_cyc(1);
    lv("R3", 1, 5);

    // R7 soft interrupts, priority and clear
    cur_req = "R7";
    wr(3, 32'h8000_0000);
    tick = 0; dev = 0;
    wr(17, 32'h0408_0000);   // levels 3 and 10 on processor 0
    rd("R7", 16, 32'h0408_0080);
    wait_cyc(1);
    lv("R7", 0, 10);
    wr(18, 32'h0400_0000);
    wait_cyc(1);
    lv("R7", 0, 3);
    wr(29, 32'h8000_0000);   // level 15 on processor 3
    wait_cyc(1);
    lv("R7", 3, 15);
    wr(30, 32'h8000_0000);
    wait_cyc(1);
    lv("R7", 3, 0);

    cur_req = "R10";
    wait_cyc(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule